// File: doc/BRIEF.md
# Non-Power-of-Two Circular FIFO

A single-clock first-in first-out queue whose depth is a free parameter. It works at depths such as six entries, and it also works at power-of-two depths. Each of the two pointers counts over a range of twice the depth. The extra lap information lets the block tell a completely full queue from an empty one without giving up a slot. Occupancy and remaining space are reported every cycle, and both come from the two pointers alone.

A producer presents a word with a valid strobe and watches the full flag. A consumer raises a ready strobe while the empty flag is low, and it takes the word from the read data port one cycle later. A parameter selects how the pointers step. The linear style counts 0 to 2·DEPTH−1 and returns to zero explicitly. The skip style keeps a storage index plus a lap bit, so for a depth of six it visits 0–5 and 8–13. Neither style uses a general modulo operation to find a storage slot.

Top module: `npot_fifo`

## Requirements
- R1: A cycle with `rst` high returns the block to empty on the next edge: `rd_empty`=1, `wr_full`=0, `fill_count`=0, `free_count`=DEPTH, `rd_data`=0.
- R2: Words leave in the order they were accepted. A read is accepted when `rd_ready`=1 and `rd_empty`=0, and the word appears on `rd_data` one clock after the accepting edge.
- R3: A write presented while `wr_full`=1 is dropped. The occupancy does not rise, and the stored contents read out later are unchanged.
- R4: A read request while `rd_empty`=1 is ignored. `rd_data` keeps its previous value and the occupancy does not fall.
- R5: `fill_count` equals accepted writes minus accepted reads since reset, and `free_count` equals DEPTH minus `fill_count`.
- R6: `wr_full` is 1 exactly when `fill_count`=DEPTH, and `rd_empty` is 1 exactly when `fill_count`=0.
- R7: When a write and a read are both accepted in the same cycle, `fill_count` stays the same.
- R8: Order and counts stay correct across many pointer laps at a depth of 6, in both the linear style (`PTR_STYLE`=0) and the skip style (`PTR_STYLE`=1).
- R9: At a power-of-two depth (8), the pointers roll over naturally and the behaviour of R2–R6 is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_data | input | DATA_W | Word to enqueue |
| wr_valid | input | 1 | Write request |
| wr_full | output | 1 | Queue holds DEPTH words |
| rd_ready | input | 1 | Read request |
| rd_data | output | DATA_W | Registered word from the last accepted read |
| rd_empty | output | 1 | Queue holds no words |
| fill_count | output | PTR_W | Words currently stored |
| free_count | output | PTR_W | Slots currently free |

## Verification
The assertions assume that `wr_valid` and `rd_ready` are known, 0 or 1, in every cycle after reset. They also assume that DEPTH is at least two. Beyond that, the properties place no limit on request patterns, because refused requests are part of the block's defined behaviour. The stimulus changes the inputs only at the falling clock edge. It runs several long phases of random traffic, some biased towards writes and some towards reads, which drives the queue into both full and empty many times and sends both pointers around many laps.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
  typedef enum logic {
    PTR_LINEAR = 1'b0,
    PTR_SKIP   = 1'b1
  } ptr_style_e;
endpackage

// File: rtl/fifo_ptr.sv
module fifo_ptr #(
  parameter int                  DEPTH = 6,
  parameter fifo_pkg::ptr_style_e STYLE = fifo_pkg::PTR_LINEAR,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [PTR_W-1:0] ptr,
  output logic [IDX_W-1:0] addr
);
  localparam bit POW2 = (DEPTH == (1 << IDX_W));

  generate
    if (POW2) begin : g_roll
      // plain binary rollover: the extra bit is the lap flag
      always_ff @(posedge clk) begin
        if (rst)      ptr <= '0;
        else if (adv) ptr <= ptr + 1'b1;
      end
      assign addr = ptr[IDX_W-1:0];
    end else if (STYLE == fifo_pkg::PTR_LINEAR) begin : g_linear
      localparam logic [PTR_W-1:0] LAST = PTR_W'(2 * DEPTH - 1);
      localparam logic [PTR_W-1:0] DEP  = PTR_W'(DEPTH);
      always_ff @(posedge clk) begin
        if (rst)           ptr <= '0;
        else if (adv) begin
          if (ptr == LAST) ptr <= '0;
          else             ptr <= ptr + 1'b1;
        end
      end
      // one conditional subtract in place of a modulo
      assign addr = IDX_W'((ptr >= DEP) ? (ptr - DEP) : ptr);
    end else begin : g_skip
      localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DEPTH - 1);
      logic [IDX_W-1:0] idx;
      logic             lap;
      always_ff @(posedge clk) begin
        if (rst) begin
          idx <= '0;
          lap <= 1'b0;
        end else if (adv) begin
          if (idx == IDX_LAST) begin
            idx <= '0;
            lap <= ~lap;
          end else begin
            idx <= idx + 1'b1;
          end
        end
      end
      assign ptr  = {lap, idx};
      assign addr = idx;
    end
  endgenerate
endmodule

// File: rtl/fifo_level.sv
module fifo_level #(
  parameter int                  DEPTH = 6,
  parameter fifo_pkg::ptr_style_e STYLE = fifo_pkg::PTR_LINEAR,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic [PTR_W-1:0] wptr,
  input  logic [PTR_W-1:0] rptr,
  output logic [PTR_W-1:0] count,
  output logic [PTR_W-1:0] free,
  output logic             full,
  output logic             empty
);
  localparam logic [PTR_W-1:0] DEP  = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] SPAN = PTR_W'(2 * DEPTH);
  localparam bit POW2 = (DEPTH == (1 << IDX_W));

  generate
    if (POW2) begin : g_roll
      assign count = wptr - rptr;
      assign full  = (wptr[IDX_W] != rptr[IDX_W]) &&
                     (wptr[IDX_W-1:0] == rptr[IDX_W-1:0]);
    end else if (STYLE == fifo_pkg::PTR_LINEAR) begin : g_linear
      always_comb begin
        count = wptr - rptr;
        if (wptr < rptr) count = count + SPAN;
      end
      assign full = (count == DEP);
    end else begin : g_skip
      logic [PTR_W-1:0] widx, ridx;
      assign widx = {1'b0, wptr[IDX_W-1:0]};
      assign ridx = {1'b0, rptr[IDX_W-1:0]};
      always_comb begin
        if (wptr[IDX_W] == rptr[IDX_W]) count = widx - ridx;
        else                            count = widx + DEP - ridx;
      end
      assign full = (wptr[IDX_W] != rptr[IDX_W]) && (widx == ridx);
    end
  endgenerate

  assign empty = (wptr == rptr);
  assign free  = DEP - count;
endmodule

// File: rtl/fifo_mem.sv
module fifo_mem #(
  parameter int DEPTH  = 6,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/npot_fifo.sv
module npot_fifo #(
  parameter int                  DATA_W    = 8,
  parameter int                  DEPTH     = 6,
  parameter fifo_pkg::ptr_style_e PTR_STYLE = fifo_pkg::PTR_LINEAR,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_valid,
  output logic              wr_full,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty,
  output logic [PTR_W-1:0]  fill_count,
  output logic [PTR_W-1:0]  free_count
);
  logic             push, pop;
  logic [PTR_W-1:0] wptr, rptr;
  logic [IDX_W-1:0] waddr, raddr;

  assign push = wr_valid & ~wr_full;
  assign pop  = rd_ready & ~rd_empty;

  fifo_ptr #(.DEPTH(DEPTH), .STYLE(PTR_STYLE)) u_wptr (
    .clk(clk), .rst(rst), .adv(push), .ptr(wptr), .addr(waddr)
  );

  fifo_ptr #(.DEPTH(DEPTH), .STYLE(PTR_STYLE)) u_rptr (
    .clk(clk), .rst(rst), .adv(pop), .ptr(rptr), .addr(raddr)
  );

  fifo_level #(.DEPTH(DEPTH), .STYLE(PTR_STYLE)) u_level (
    .wptr(wptr), .rptr(rptr), .count(fill_count), .free(free_count),
    .full(wr_full), .empty(rd_empty)
  );

  fifo_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .rst(rst), .we(push), .waddr(waddr), .wdata(wr_data),
    .re(pop), .raddr(raddr), .rdata(rd_data)
  );
endmodule

// File: rtl/npot_fifo_chk.sv
module npot_fifo_chk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 6,
  parameter int PTR_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_valid,
  input logic              wr_full,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_empty,
  input logic [PTR_W-1:0]  fill_count,
  input logic [PTR_W-1:0]  free_count
);
  localparam logic [PTR_W-1:0] DEP = PTR_W'(DEPTH);

  a_r1_reset_empty: assert property (@(posedge clk)
    rst |=> (rd_empty && !wr_full && fill_count == '0 && rd_data == '0));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (wr_full && !rd_ready) |=> (wr_full && fill_count == $past(fill_count)));

  a_r4_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (rd_empty && !wr_valid) |=> (rd_empty && $stable(rd_data)));

  a_r5_push_count: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_full && !rd_ready) |=> (fill_count == $past(fill_count) + 1'b1));

  a_r5_pop_count: assert property (@(posedge clk) disable iff (rst)
    (rd_ready && !rd_empty && !wr_valid) |=> (fill_count == $past(fill_count) - 1'b1));

  a_r5_space_sum: assert property (@(posedge clk) disable iff (rst)
    (fill_count + free_count) == DEP);

  a_r6_bounds: assert property (@(posedge clk) disable iff (rst)
    (fill_count <= DEP) && !(wr_full && rd_empty));

  a_r7_balance: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && rd_ready && !wr_full && !rd_empty) |=> $stable(fill_count));
endmodule

bind npot_fifo npot_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_full(wr_full),
  .rd_ready(rd_ready), .rd_data(rd_data), .rd_empty(rd_empty),
  .fill_count(fill_count), .free_count(free_count)
);

// File: tb/npot_fifo_tb_top.sv
`timescale 1ns/1ps
module npot_fifo_tb_top;
  localparam int NDUT = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] wr_data = '0;
  logic       wr_valid = 1'b0;
  logic       rd_ready = 1'b0;

  logic       full_o  [NDUT];
  logic       empty_o [NDUT];
  logic [7:0] rdd_o   [NDUT];
  logic [3:0] cnt_o   [NDUT];
  logic [3:0] free_o  [NDUT];

  always #2.5 clk = ~clk;

  // six deep, linear pointers
  npot_fifo #(.DATA_W(8), .DEPTH(6), .PTR_STYLE(fifo_pkg::PTR_LINEAR)) dut_i (
    .clk(clk), .rst(rst), .wr_data(wr_data), .wr_valid(wr_valid), .wr_full(full_o[0]),
    .rd_ready(rd_ready), .rd_data(rdd_o[0]), .rd_empty(empty_o[0]),
    .fill_count(cnt_o[0]), .free_count(free_o[0]));

  // six deep, skip-count pointers
  npot_fifo #(.DATA_W(8), .DEPTH(6), .PTR_STYLE(fifo_pkg::PTR_SKIP)) dut_skip_i (
    .clk(clk), .rst(rst), .wr_data(wr_data), .wr_valid(wr_valid), .wr_full(full_o[1]),
    .rd_ready(rd_ready), .rd_data(rdd_o[1]), .rd_empty(empty_o[1]),
    .fill_count(cnt_o[1]), .free_count(free_o[1]));

  // eight deep, natural rollover
  npot_fifo #(.DATA_W(8), .DEPTH(8), .PTR_STYLE(fifo_pkg::PTR_LINEAR)) dut_p2_i (
    .clk(clk), .rst(rst), .wr_data(wr_data), .wr_valid(wr_valid), .wr_full(full_o[2]),
    .rd_ready(rd_ready), .rd_data(rdd_o[2]), .rd_empty(empty_o[2]),
    .fill_count(cnt_o[2]), .free_count(free_o[2]));

  // reference model: a circular array per device
  int         mdepth [NDUT] = '{6, 6, 8};
  logic [7:0] mbuf   [NDUT][8];
  int         mhead  [NDUT];
  int         mcnt   [NDUT];
  logic [7:0] mexp   [NDUT];

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;
  logic [7:0] seq = 8'h01;

  // table: {push, pop, tag[1:0], expected count at depth 6}
  // tag 0 -> R5, 1 -> R3, 2 -> R4, 3 -> R7
  localparam logic [7:0] TBL [16] = '{
    {2'b10, 2'd0, 4'd1}, {2'b10, 2'd0, 4'd2}, {2'b11, 2'd3, 4'd2}, {2'b10, 2'd0, 4'd3},
    {2'b10, 2'd0, 4'd4}, {2'b10, 2'd0, 4'd5}, {2'b10, 2'd0, 4'd6}, {2'b10, 2'd1, 4'd6},
    {2'b11, 2'd1, 4'd5}, {2'b01, 2'd0, 4'd4}, {2'b01, 2'd0, 4'd3}, {2'b01, 2'd0, 4'd2},
    {2'b01, 2'd0, 4'd1}, {2'b01, 2'd0, 4'd0}, {2'b01, 2'd2, 4'd0}, {2'b11, 2'd2, 4'd1}
  };

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NDUT; i++) begin
      mhead[i] = 0;
      mcnt[i]  = 0;
      mexp[i]  = 8'h00;
    end
  endtask

  // compare every output of every device with the model
  task automatic check_all(string dtag);
    for (int i = 0; i < NDUT; i++) begin
      string t;
      t = (i == 2) ? "R9" : dtag;
      chk(t, $sformatf("dev%0d rd_data", i), int'(rdd_o[i]), int'(mexp[i]));
      chk("R5", $sformatf("dev%0d fill_count", i), int'(cnt_o[i]), mcnt[i]);
      chk("R5", $sformatf("dev%0d free_count", i), int'(free_o[i]), mdepth[i] - mcnt[i]);
      chk("R6", $sformatf("dev%0d wr_full", i), int'(full_o[i]), int'(mcnt[i] == mdepth[i]));
      chk("R6", $sformatf("dev%0d rd_empty", i), int'(empty_o[i]), int'(mcnt[i] == 0));
    end
  endtask

  // one cycle: drive at the falling edge, update the model, check after the next edge
  task automatic step(bit push, bit pop, string dtag);
    wr_valid = push;
    rd_ready = pop;
    wr_data  = seq;
    for (int i = 0; i < NDUT; i++) begin
      bit aw, ar;
      aw = push && (mcnt[i] < mdepth[i]);
      ar = pop && (mcnt[i] > 0);
      if (ar) begin
        mexp[i]  = mbuf[i][mhead[i]];
        mhead[i] = (mhead[i] + 1) % mdepth[i];
      end
      if (aw) mbuf[i][(mhead[i] + mcnt[i] - int'(ar)) % mdepth[i]] = seq;
      mcnt[i] = mcnt[i] + int'(aw) - int'(ar);
    end
    seq = seq + 8'd1;
    @(posedge clk);
    @(negedge clk);
    check_all(dtag);
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state held in reset
    for (int i = 0; i < NDUT; i++) begin
      chk("R1", "reset rd_empty", int'(empty_o[i]), 1);
      chk("R1", "reset wr_full", int'(full_o[i]), 0);
      chk("R1", "reset fill_count", int'(cnt_o[i]), 0);
      chk("R1", "reset free_count", int'(free_o[i]), mdepth[i]);
      chk("R1", "reset rd_data", int'(rdd_o[i]), 0);
    end
    rst = 1'b0;

    // table walk
    for (int k = 0; k < 16; k++) begin
      string t;
      case (TBL[k][5:4])
        2'd1:    t = "R3";
        2'd2:    t = "R4";
        2'd3:    t = "R7";
        default: t = "R5";
      endcase
      step(TBL[k][7], TBL[k][6], "R2");
      chk(t, $sformatf("table %0d dev0 count", k), int'(cnt_o[0]), int'(TBL[k][3:0]));
      chk(t, $sformatf("table %0d dev1 count", k), int'(cnt_o[1]), int'(TBL[k][3:0]));
    end

    // long random traffic, biased phases to hit full and empty, many laps
    for (int ph = 0; ph < 8; ph++) begin
      for (int c = 0; c < 400; c++) begin
        int r;
        bit p, q;
        r = int'($urandom_range(0, 99));
        p = (ph % 2 == 0) ? (r < 75) : (r < 30);
        r = int'($urandom_range(0, 99));
        q = (ph % 2 == 0) ? (r < 30) : (r < 75);
        step(p, q, "R8");
      end
    end

    // drain, then a read request on an empty queue
    repeat (10) step(1'b0, 1'b1, "R2");
    step(1'b0, 1'b1, "R4");
    for (int i = 0; i < NDUT; i++)
      chk("R4", $sformatf("dev%0d empty after drain", i), int'(empty_o[i]), 1);

    // fill past full, then read back in order
    repeat (9) step(1'b1, 1'b0, "R3");
    repeat (9) step(1'b0, 1'b1, "R3");

    // reset mid-stream with a write pending
    repeat (3) step(1'b1, 1'b0, "R2");
    rst = 1'b1;
    wr_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    wr_valid = 1'b0;
    model_reset();
    for (int i = 0; i < NDUT; i++) begin
      chk("R1", "mid reset rd_empty", int'(empty_o[i]), 1);
      chk("R1", "mid reset fill_count", int'(cnt_o[i]), 0);
      chk("R1", "mid reset rd_data", int'(rdd_o[i]), 0);
    end
    step(1'b1, 1'b0, "R2");
    step(1'b0, 1'b1, "R2");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule